// File: doc/BRIEF.md
# Partitioned Byte-by-Scalar Multiplier

This block multiplies each of four unsigned 8-bit pixel lanes, packed into a 32-bit word, by one signed 16-bit scalar. Each lane keeps a rounded 16-bit slice of its product, and the four slices are packed into a 64-bit result. The scalar comes from a second 32-bit word. A per-operation select bit chooses the upper or the lower half of that word.

Operations enter with `in_valid`, and each result appears one clock later with `out_valid`. The result register is loaded only when an operation is accepted. It keeps its value between operations. Every result is built from the two operands of its own operation and nothing else.

Top module: `byte_scalar_mul`

## Requirements
- R1: Each 8-bit lane of `pix_word` is zero-extended. It is multiplied by the selected scalar, taken as a signed 16-bit value, into a signed product of at least 25 bits.
- R2: When `use_upper` is 1, the scalar is `scl_word[31:16]`. When `use_upper` is 0, the scalar is `scl_word[15:0]`.
- R3: If the low 8 bits of a lane product exceed 0x7F, 0x100 is added to the product. The lane result is bits 23:8 of the adjusted product. A low byte of exactly 0x80 rounds up, and a low byte of 0x7F does not.
- R4: Lane r takes `pix_word[8r+7:8r]` and writes `prod_word[16r+15:16r]`, for r from 0 to 3. Lane 0 is the least significant in both words.
- R5: A result depends only on the operands of its own operation. No earlier content of `prod_word` is merged into it.
- R6: An operation presented with `in_valid` high sets `out_valid` high, and puts its result on `prod_word`, exactly one clock later. `out_valid` is low in the cycle after any cycle in which `in_valid` is low.
- R7: While `in_valid` is low, `prod_word` keeps its value, whatever the operands do.
- R8: A synchronous active-high `rst` clears `out_valid` and `prod_word`.
- R9: Operand extremes are computed exactly. These include a scalar of -32768, a scalar of 0x7FFF and a pixel of 0xFF.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Operation present this cycle |
| use_upper | input | 1 | 1 selects the upper scalar half, 0 selects the lower half |
| pix_word | input | 32 | Four unsigned pixel bytes, lane 0 in bits 7:0 |
| scl_word | input | 32 | Word holding two signed 16-bit scalars |
| out_valid | output | 1 | Result valid, one clock after `in_valid` |
| prod_word | output | 64 | Four 16-bit lane results, lane 0 in bits 15:0 |

## Verification
The main function is driven with several kinds of operand:
- Distinct bytes in every lane, with a different scalar in each half. This separates lane placement errors from half-select errors.
- Products whose low byte is exactly 0x80 or 0x7F. These pin down the rounding threshold.
- The scalar extremes against a pixel of 0xFF. These expose a product that is too narrow or a byte that is treated as signed.
- Randomized operands, checked against a reference computed in the bench.
- An operation followed by all-zero operands, and idle cycles with moving operands. These show that no stale data is merged into a result and that nothing leaks into the held result.

// File: rtl/byte_scalar_mul.sv
module byte_scalar_mul #(
  parameter int LANES  = 4,
  parameter int LANE_W = 8,
  parameter int SCL_W  = 16
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     in_valid,
  input  logic                     use_upper,
  input  logic [LANES*LANE_W-1:0]  pix_word,
  input  logic [2*SCL_W-1:0]       scl_word,
  output logic                     out_valid,
  output logic [LANES*SCL_W-1:0]   prod_word
);
  localparam int PW    = SCL_W + LANE_W + 1;
  localparam int OUT_W = LANES * SCL_W;
  localparam logic [PW-1:0] RND = PW'(1) << LANE_W;
  localparam logic [LANE_W-1:0] HALF = LANE_W'((1 << (LANE_W - 1)) - 1);

  logic signed [SCL_W-1:0] scalar;
  logic [OUT_W-1:0]        next_word;

  assign scalar = use_upper ? scl_word[2*SCL_W-1:SCL_W] : scl_word[SCL_W-1:0];

  for (genvar r = 0; r < LANES; r++) begin : g_lane
    logic signed [LANE_W:0] pix_x;
    logic signed [PW-1:0]   prod;
    logic signed [PW-1:0]   adj;

    assign pix_x = {1'b0, pix_word[r*LANE_W +: LANE_W]};
    assign prod  = PW'(scalar) * PW'(pix_x);
    assign adj   = prod + ((prod[LANE_W-1:0] > HALF) ? RND : '0);
    assign next_word[r*SCL_W +: SCL_W] = SCL_W'(adj >>> LANE_W);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid <= 1'b0;
      prod_word <= '0;
    end else begin
      out_valid <= in_valid;
      if (in_valid) prod_word <= next_word;
    end
  end

  // R6: valid travels exactly one stage
  assert_valid_follows_R6: assert property (@(posedge clk) disable iff (rst)
    in_valid |=> out_valid);
  assert_valid_drops_R6: assert property (@(posedge clk) disable iff (rst)
    !in_valid |=> !out_valid);
  // R7: idle cycles leave the result untouched
  assert_result_held_R7: assert property (@(posedge clk) disable iff (rst)
    !in_valid |=> $stable(prod_word));
  // R5: zero pixels give zero, no earlier content survives
  assert_zero_pixels_R5: assert property (@(posedge clk) disable iff (rst)
    (in_valid && pix_word == '0) |=> (prod_word == '0));
  // R2: a zero in the selected half gives zero whatever the other half holds
  assert_zero_scalar_R2: assert property (@(posedge clk) disable iff (rst)
    (in_valid && scalar == '0) |=> (prod_word == '0));
endmodule

// File: tb/byte_scalar_mul_tb.sv
module byte_scalar_mul_tb_top;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        in_valid = 1'b0;
  logic        use_upper = 1'b0;
  logic [31:0] pix_word = '0;
  logic [31:0] scl_word = '0;
  logic        out_valid;
  logic [63:0] prod_word;

  int vectors = 0;
  int miscompares = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  byte_scalar_mul dut_i (
    .clk(clk), .rst(rst), .in_valid(in_valid), .use_upper(use_upper),
    .pix_word(pix_word), .scl_word(scl_word),
    .out_valid(out_valid), .prod_word(prod_word)
  );

  function automatic logic [15:0] ref_lane(input logic [7:0] b, input logic [15:0] s);
    int p;
    p = int'($signed(s)) * int'(b);
    if ((p & 255) > 127) p = p + 256;
    p = p >>> 8;
    return p[15:0];
  endfunction

  function automatic logic [63:0] ref_word(input logic [31:0] pw, input logic [31:0] sw,
                                           input logic up);
    logic [15:0] s;
    logic [63:0] w;
    s = up ? sw[31:16] : sw[15:0];
    for (int r = 0; r < 4; r++) w[16*r +: 16] = ref_lane(pw[8*r +: 8], s);
    return w;
  endfunction

  task automatic check64(input string req, input logic [63:0] act, input logic [63:0] exp);
    vectors++;
    if (act !== exp) begin
      miscompares++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic check1(input string req, input logic act, input logic exp);
    vectors++;
    if (act !== exp) begin
      miscompares++;
      $display("FAIL %s: actual %b expected %b", req, act, exp);
    end
  endtask

  task automatic apply(input string req, input logic [31:0] pw, input logic [31:0] sw,
                       input logic up);
    @(negedge clk);
    in_valid = 1'b1; pix_word = pw; scl_word = sw; use_upper = up;
    @(negedge clk);
    in_valid = 1'b0;
    check1({req, " valid"}, out_valid, 1'b1);
    check64(req, prod_word, ref_word(pw, sw, up));
  endtask

  task automatic t_reset;
    @(negedge clk);
    check1("R8 valid", out_valid, 1'b0);
    check64("R8", prod_word, 64'h0);
  endtask

  task automatic t_select;
    apply("R2 upper", 32'h0403_0201, 32'h0100_0003, 1'b1);
    check64("R2 upper value", prod_word, 64'h0004_0003_0002_0001);
    apply("R2 lower", 32'h0403_0201, 32'h0100_0003, 1'b0);
  endtask

  task automatic t_round;
    apply("R3 0x80 rounds up", 32'h0000_0001, 32'h0000_0080, 1'b0);
    check64("R3 0x80 value", prod_word, 64'h0000_0000_0000_0001);
    apply("R3 0x7F stays", 32'h0000_0001, 32'h0000_007F, 1'b0);
    check64("R3 0x7F value", prod_word, 64'h0);
    apply("R3 negative", 32'h0000_0001, 32'h0000_FF80, 1'b0);
  endtask

  task automatic t_lanes;
    apply("R4 distinct lanes", 32'h4010_0402, 32'h0000_0100, 1'b0);
    check64("R4 placement", prod_word, 64'h0040_0010_0004_0002);
  endtask

  task automatic t_extremes;
    apply("R9 min scalar", 32'hFF00_80FF, 32'h8000_0000, 1'b1);
    check64("R9 min x FF", {48'h0, prod_word[15:0]}, 64'h0000_0000_0000_8080);
    apply("R9 max scalar", 32'hFFFF_FFFF, 32'h0000_7FFF, 1'b0);
    apply("R9 both extremes", 32'hFF01_FF01, 32'h7FFF_8000, 1'b1);
  endtask

  task automatic t_no_merge;
    apply("R5 first", 32'hFFFF_FFFF, 32'h7FFF_7FFF, 1'b0);
    apply("R5 zero after", 32'h0000_0000, 32'h1234_5678, 1'b1);
    check64("R5 zero value", prod_word, 64'h0);
  endtask

  task automatic t_hold;
    logic [63:0] held;
    apply("R7 load", 32'h1122_3344, 32'h0000_5555, 1'b0);
    held = prod_word;
    for (int i = 0; i < 3; i++) begin
      pix_word = 32'hDEAD_BEEF + i;
      scl_word = 32'hCAFE_F00D;
      use_upper = i[0];
      @(negedge clk);
      check1("R6 idle valid", out_valid, 1'b0);
      check64("R7 held", prod_word, held);
    end
  endtask

  task automatic t_random;
    for (int i = 0; i < 200; i++) begin
      apply("R1 random", $urandom, $urandom, 1'($urandom));
    end
  endtask

  task automatic t_reset_mid;
    apply("R8 preload", 32'h0102_0304, 32'h0100_0100, 1'b1);
    rst = 1'b1;
    @(negedge clk);
    rst = 1'b0;
    check1("R8 mid valid", out_valid, 1'b0);
    check64("R8 mid", prod_word, 64'h0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    t_reset();
    t_select();
    t_round();
    t_lanes();
    t_extremes();
    t_no_merge();
    t_hold();
    t_random();
    t_reset_mid();
    done = 1'b1;
    $display("  == %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      vectors++;
      miscompares++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("  == %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
    end
  end
endmodule